// File: doc/BRIEF.md
# Critical-Word-First Cache Line Fill Unit

This unit brings one four-word cache line in from memory after a miss. The cache controller hands it the missing address. Optionally, it also hands over a store to fold in: data plus per-byte enables. The unit then issues one burst read whose address is the word that caused the miss. The memory side returns that word first. The remaining words follow in ascending order and wrap back to the start of the line.

As each beat arrives, the unit places it in its slot of a line buffer. When the first beat arrives, any enabled store bytes overwrite the corresponding bytes of that word. Once the fourth beat is in, a one-cycle completion pulse tells the controller the assembled line is ready to be written. If any beat carries an error, the fill stops at once: a machine-check pulse is raised and no completion is signalled, so the cache contents are never touched. Winning the bus is handled elsewhere.

Top module: `lineFillUnit`

## Requirements
- R1: After reset is released, `busy`, `burstReq`, `lineDone` and `machineCheck` are all 0.
- R2: A request is taken on a rising edge where `reqValid` is 1 and `busy` is 0. From the next cycle, `busy` stays 1 until the cycle in which `lineDone` or `machineCheck` is 1; it is 0 in that cycle.
- R3: `burstReq` is high for exactly one cycle, the cycle after the request is taken. During that cycle, `burstAddr` equals `reqAddr` with its two low byte-offset bits cleared.
- R4: The critical index c is `reqAddr[3:2]`. Beat k (k = 0..3) lands in word (c+k) mod 4 of `lineData`, and word w occupies bits [32w+31:32w].
- R5: When `storeEn` was 1 at request time, byte b of the critical word comes from `storeData[8b+7:8b]` where `storeBe[b]` is 1. It comes from the beat data where `storeBe[b]` is 0.
- R6: When `storeEn` was 0 at request time, the critical word equals the bus data unchanged, whatever `storeBe` holds.
- R7: `lineDone` is a one-cycle pulse in the cycle after the fourth error-free beat is accepted. `lineData` holds the assembled line in that cycle.
- R8: A beat with `beatValid` and `beatErr` both 1 ends the fill. `machineCheck` pulses in the next cycle, and `lineDone` never rises for that fill.
- R9: `reqValid` while `busy` is 1 is ignored: no further `burstReq` is issued, and the fill in progress completes with its own line.
- R10: `beatValid` while no fill is waiting for beats is ignored and produces no `lineDone` or `machineCheck`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Miss request strobe |
| reqAddr | input | ADDR_W | Byte address that missed |
| storeEn | input | 1 | Merge pending store into the critical word |
| storeData | input | WORD_W | Store data |
| storeBe | input | WORD_W/8 | Store byte enables |
| busy | output | 1 | Fill in progress |
| burstReq | output | 1 | One-cycle burst read request |
| burstAddr | output | ADDR_W | Word-aligned start address of the burst |
| beatValid | input | 1 | Burst beat present |
| beatData | input | WORD_W | Burst beat data |
| beatErr | input | 1 | Bus error on this beat |
| lineDone | output | 1 | Line complete pulse |
| lineData | output | WORDS*WORD_W | Assembled line, word 0 in low bits |
| machineCheck | output | 1 | Bus error pulse |

## Verification
A request taken on one edge shows `burstReq` and `burstAddr` in the next cycle. The beat that is the fourth, or the erroring one, shows its result in the cycle after the edge that accepts it. The driver applies inputs just after a rising edge. Every output is sampled on the falling edge of the cycle where it is due. The driver computes each expected line or error from the address, store and beat values and pushes it into a queue. The monitor pops an item only when a `lineDone` or `machineCheck` is seen, so a pulse that arrives early, late, twice or not at all shows up as a mismatch.

// File: rtl/lfuPkg.sv
package lfuPkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_BEAT = 2'd2
  } lfuState_t;

  typedef struct packed {
    logic capture;
    logic writeBeat;
  } lfuStrobes_t;
endpackage

// File: rtl/lfuDatapath.sv
module lfuDatapath
  import lfuPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int WORDS  = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  lfuStrobes_t             strobes,
  input  logic [ADDR_W-1:0]       reqAddr,
  input  logic                    storeEn,
  input  logic [WORD_W-1:0]       storeData,
  input  logic [WORD_W/8-1:0]     storeBe,
  input  logic [WORD_W-1:0]       beatData,
  output logic                    lastBeat,
  output logic [ADDR_W-1:0]       burstAddr,
  output logic [WORDS*WORD_W-1:0] lineData
);
  localparam int BYTES    = WORD_W / 8;
  localparam int BYTE_OFF = $clog2(BYTES);
  localparam int IDX_W    = $clog2(WORDS);

  logic [ADDR_W-BYTE_OFF-1:0] wordAddrQ;
  logic                       storeEnQ;
  logic [WORD_W-1:0]          storeDataQ;
  logic [BYTES-1:0]           storeBeQ;
  logic [IDX_W-1:0]           beatCnt;
  logic [IDX_W-1:0]           critIdx;
  logic [IDX_W-1:0]           slotIdx;
  logic [WORD_W-1:0]          mergedWord;
  logic [WORD_W-1:0]          lineBuf [WORDS];

  assign critIdx   = wordAddrQ[IDX_W-1:0];
  assign slotIdx   = critIdx + beatCnt;
  assign lastBeat  = (beatCnt == IDX_W'(WORDS - 1));
  assign burstAddr = {wordAddrQ, {BYTE_OFF{1'b0}}};

  // Byte-wise merge of the pending store into the critical beat only.
  for (genvar b = 0; b < BYTES; b++) begin : g_merge
    always_comb begin
      if (storeEnQ && storeBeQ[b] && (beatCnt == '0))
        mergedWord[b*8 +: 8] = storeDataQ[b*8 +: 8];
      else
        mergedWord[b*8 +: 8] = beatData[b*8 +: 8];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordAddrQ  <= '0;
      storeEnQ   <= 1'b0;
      storeDataQ <= '0;
      storeBeQ   <= '0;
      beatCnt    <= '0;
    end else if (strobes.capture) begin
      wordAddrQ  <= reqAddr[ADDR_W-1:BYTE_OFF];
      storeEnQ   <= storeEn;
      storeDataQ <= storeData;
      storeBeQ   <= storeBe;
      beatCnt    <= '0;
    end else if (strobes.writeBeat) begin
      beatCnt    <= beatCnt + 1'b1;
    end
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_line
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        lineBuf[w] <= '0;
      else if (strobes.writeBeat && (slotIdx == IDX_W'(w)))
        lineBuf[w] <= mergedWord;
    end
    assign lineData[w*WORD_W +: WORD_W] = lineBuf[w];
  end
endmodule

// File: rtl/lfuControl.sv
module lfuControl
  import lfuPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        beatValid,
  input  logic        beatErr,
  input  logic        lastBeat,
  output lfuStrobes_t strobes,
  output logic        busy,
  output logic        burstReq,
  output logic        lineDone,
  output logic        machineCheck
);
  lfuState_t state, stateNext;
  logic      doneNext, errNext;

  always_comb begin
    stateNext         = state;
    doneNext          = 1'b0;
    errNext           = 1'b0;
    strobes.capture   = 1'b0;
    strobes.writeBeat = 1'b0;
    unique case (state)
      ST_IDLE: if (reqValid) begin
        strobes.capture = 1'b1;
        stateNext       = ST_REQ;
      end
      ST_REQ: stateNext = ST_BEAT;
      ST_BEAT: if (beatValid) begin
        if (beatErr) begin
          errNext   = 1'b1;
          stateNext = ST_IDLE;
        end else begin
          strobes.writeBeat = 1'b1;
          if (lastBeat) begin
            doneNext  = 1'b1;
            stateNext = ST_IDLE;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      lineDone     <= 1'b0;
      machineCheck <= 1'b0;
    end else begin
      state        <= stateNext;
      lineDone     <= doneNext;
      machineCheck <= errNext;
    end
  end

  assign busy     = (state != ST_IDLE);
  assign burstReq = (state == ST_REQ);
endmodule

// File: rtl/lineFillUnit.sv
module lineFillUnit
  import lfuPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int WORDS  = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  input  logic [ADDR_W-1:0]       reqAddr,
  input  logic                    storeEn,
  input  logic [WORD_W-1:0]       storeData,
  input  logic [WORD_W/8-1:0]     storeBe,
  output logic                    busy,
  output logic                    burstReq,
  output logic [ADDR_W-1:0]       burstAddr,
  input  logic                    beatValid,
  input  logic [WORD_W-1:0]       beatData,
  input  logic                    beatErr,
  output logic                    lineDone,
  output logic [WORDS*WORD_W-1:0] lineData,
  output logic                    machineCheck
);
  lfuStrobes_t strobes;
  logic        lastBeat;

  lfuControl i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .beatValid(beatValid),
    .beatErr(beatErr), .lastBeat(lastBeat), .strobes(strobes), .busy(busy),
    .burstReq(burstReq), .lineDone(lineDone), .machineCheck(machineCheck)
  );

  lfuDatapath #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .WORDS(WORDS)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .reqAddr(reqAddr),
    .storeEn(storeEn), .storeData(storeData), .storeBe(storeBe),
    .beatData(beatData), .lastBeat(lastBeat), .burstAddr(burstAddr),
    .lineData(lineData)
  );
endmodule

// File: rtl/lfuChecker.sv
module lfuChecker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              busy,
  input logic              burstReq,
  input logic [ADDR_W-1:0] burstAddr,
  input logic              lineDone,
  input logic              machineCheck
);
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    burstReq |=> !burstReq); // R3
  AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    burstReq |-> (burstAddr[1:0] == 2'b00)); // R3
  AST_BUSY_STARTS_WITH_REQ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> burstReq); // R2
  AST_ACCEPT_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy) |=> burstReq); // R2
  AST_NO_REQ_WHILE_FILLING: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !burstReq) |=> !burstReq); // R9
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    lineDone |-> !busy); // R7
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    lineDone |=> !lineDone); // R7
  AST_ERR_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    machineCheck |-> !busy); // R8
  AST_DONE_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(lineDone && machineCheck)); // R8
endmodule

bind lineFillUnit lfuChecker #(.ADDR_W(ADDR_W)) i_lfuChecker (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .busy(busy),
  .burstReq(burstReq), .burstAddr(burstAddr), .lineDone(lineDone),
  .machineCheck(machineCheck)
);

// File: tb/test_lineFillUnit.sv
module test_lineFillUnit;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int WORD_W = 32;
  localparam int WORDS  = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic storeEn = 1'b0;
  logic [WORD_W-1:0] storeData = '0;
  logic [3:0] storeBe = '0;
  logic busy, burstReq, lineDone, machineCheck;
  logic [ADDR_W-1:0] burstAddr;
  logic beatValid = 1'b0;
  logic [WORD_W-1:0] beatData = '0;
  logic beatErr = 1'b0;
  logic [WORDS*WORD_W-1:0] lineData;

  typedef struct { logic isErr; logic [127:0] line; string tag; } expItem_t;
  expItem_t expQ[$];
  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lineFillUnit #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .WORDS(WORDS)) i_lineFillUnit (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .storeEn(storeEn), .storeData(storeData), .storeBe(storeBe), .busy(busy),
    .burstReq(burstReq), .burstAddr(burstAddr), .beatValid(beatValid),
    .beatData(beatData), .beatErr(beatErr), .lineDone(lineDone),
    .lineData(lineData), .machineCheck(machineCheck)
  );

  task automatic check(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // Monitor: pops one expected item per result pulse, sampled on falling edge.
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && (lineDone || machineCheck)) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R10 unexpected result", {126'd0, lineDone, machineCheck}, '0);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          check(machineCheck == e.isErr && lineDone == !e.isErr, {e.tag, " kind"},
                {126'd0, lineDone, machineCheck}, {126'd0, !e.isErr, e.isErr});
          check(!busy, {e.tag, " busy low at result (R2)"}, 128'(busy), '0);
          if (!e.isErr) check(lineData == e.line, {e.tag, " line"}, lineData, e.line);
        end
      end
    end
  end

  // Driver: one fill; errBeat < 0 means no error.
  task automatic doFill(input logic [31:0] addr, input bit sEn, input logic [31:0] sData,
                        input logic [3:0] sBe, input logic [31:0] b0, input logic [31:0] b1,
                        input logic [31:0] b2, input logic [31:0] b3, input int errBeat,
                        input string tag);
    logic [31:0] beats [4];
    expItem_t e;
    int crit;
    beats[0] = b0; beats[1] = b1; beats[2] = b2; beats[3] = b3;
    crit = int'(addr[3:2]);
    e.isErr = (errBeat >= 0);
    e.tag = tag;
    e.line = '0;
    for (int k = 0; k < 4; k++) begin
      logic [31:0] w;
      w = beats[k];
      if (k == 0 && sEn)
        for (int b = 0; b < 4; b++) if (sBe[b]) w[b*8 +: 8] = sData[b*8 +: 8];
      e.line[((crit + k) % 4) * 32 +: 32] = w;
    end
    expQ.push_back(e);
    reqValid = 1'b1; reqAddr = addr; storeEn = sEn; storeData = sData; storeBe = sBe;
    tick();
    reqValid = 1'b0; storeEn = 1'b0; storeData = '0; storeBe = 4'hF;
    @(negedge clk);
    check(burstReq && busy, {tag, " R3 burstReq/busy after accept"},
          {126'd0, burstReq, busy}, 128'd3);
    check(burstAddr == {addr[31:2], 2'b00}, {tag, " R3 burstAddr"},
          128'(burstAddr), 128'({addr[31:2], 2'b00}));
    tick();
    for (int k = 0; k < 4; k++) begin
      beatValid = 1'b1; beatData = beats[k]; beatErr = (k == errBeat);
      tick();
      if (k == errBeat) break;
    end
    beatValid = 1'b0; beatErr = 1'b0; beatData = '0;
    @(negedge clk);
    check(!busy, {tag, " R2 busy dropped"}, 128'(busy), '0);
    tick();
  endtask

  initial begin
    tick();
    #1;
    check(!busy && !burstReq && !lineDone && !machineCheck, "R1 reset state",
          {124'd0, busy, burstReq, lineDone, machineCheck}, '0);
    rstN = 1'b1;
    tick();
    check(!busy && !burstReq && !lineDone && !machineCheck, "R1 after release",
          {124'd0, busy, burstReq, lineDone, machineCheck}, '0);

    // R4 wrap order from every starting word
    doFill(32'h1000, 0, 0, 0, 32'hA0, 32'hA1, 32'hA2, 32'hA3, -1, "R4 crit0");
    doFill(32'h2004, 0, 0, 0, 32'hB0, 32'hB1, 32'hB2, 32'hB3, -1, "R4 crit1");
    doFill(32'h300B, 0, 0, 0, 32'hC0, 32'hC1, 32'hC2, 32'hC3, -1, "R4 crit2");
    doFill(32'h400E, 0, 0, 0, 32'hD0, 32'hD1, 32'hD2, 32'hD3, -1, "R4 R7 crit3");
    // R5 store merge with partial and full byte enables
    doFill(32'h5008, 1, 32'h11223344, 4'b0101, 32'hAAAAAAAA, 32'h1, 32'h2, 32'h3, -1,
           "R5 merge partial");
    doFill(32'h600C, 1, 32'hDEADBEEF, 4'b1111, 32'h55555555, 32'h6, 32'h7, 32'h8, -1,
           "R5 merge full");
    // R6 merge disabled although byte enables set
    doFill(32'h7004, 0, 32'hFFFFFFFF, 4'b1111, 32'h12345678, 32'h9, 32'hA, 32'hB, -1,
           "R6 no merge");
    // R8 errors on first and last beat
    doFill(32'h8000, 1, 32'h1, 4'h1, 32'hE0, 32'hE1, 32'hE2, 32'hE3, 0, "R8 err beat0");
    doFill(32'h9008, 0, 0, 0, 32'hF0, 32'hF1, 32'hF2, 32'hF3, 3, "R8 err beat3");

    // R9: request while busy ignored
    begin
      expItem_t e;
      e.isErr = 1'b0; e.tag = "R9 busy request";
      e.line = {32'h23, 32'h22, 32'h21, 32'h20};
      expQ.push_back(e);
      reqValid = 1'b1; reqAddr = 32'hA000; tick();
      reqAddr = 32'hB00C; tick();
      tick();
      for (int k = 0; k < 4; k++) begin
        beatValid = 1'b1; beatData = 32'h20 + k;
        @(negedge clk);
        check(!burstReq, "R9 no burstReq while busy", 128'(burstReq), '0);
        tick();
      end
      reqValid = 1'b0; beatValid = 1'b0;
      tick(); tick(); tick();
    end

    // R10: beats with nothing pending
    for (int k = 0; k < 3; k++) begin
      beatValid = 1'b1; beatErr = (k == 1); beatData = 32'hBAD0 + k;
      tick();
      check(!busy, "R10 stray beat leaves idle", 128'(busy), '0);
    end
    beatValid = 1'b0; beatErr = 1'b0;
    tick(); tick();

    check(expQ.size() == 0, "R7 all results seen", 128'(expQ.size()), '0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule